// File: doc/BRIEF.md
# Transmit Lane Bit-Delay Aligner

This block sits in one transmit lane ahead of the serializer. It delays the serial bit stream of that lane by a programmable whole number of bit times, from zero up to W-1. It does this by moving the parallel word boundary: the top bits of one word are carried into the next word. Bit 0 of every word is the first bit serialized. An output word therefore begins with the last `slip` bits of the previous input word, followed by the first W-`slip` bits of the current word. Each lane instance has its own slip setting, so a system can pad early lanes and line up all lanes at the far end.

The slip input is a held level, not a pulse. A fixed value gives a fixed total delay that never accumulates. The value is sampled together with each accepted input word, so a change takes effect at a word boundary. Values above W-1 are clamped to W-1.

Data moves over a valid/ready stream on each side, one word per clock at full rate. An input word is taken when `in_valid && in_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An output word is offered with `out_valid` and stays stable until `out_ready` takes it.

Top module: `tx_lane_slip`

## Requirements
- R1: While reset is held, and on the first clock after it, `out_valid` is 0. The carry history is cleared, so the first word after reset with slip s has zeros in output bits [s-1:0].
- R2: With slip 0, each accepted word appears unchanged on `out_data` on the clock after it is accepted.
- R3: With effective slip s, output bit j equals bit W-s+j of the previously accepted word for j < s, and bit j-s of the word being accepted for j >= s. Bit 0 is the first bit serialized.
- R4: The largest effective slip, W-1, delays the stream by W-1 bit times. Only bit W-1 of the output comes from the current word.
- R5: Any slip control value greater than W-1 acts as W-1. The control is SW bits wide, SW=6 by default.
- R6: A constant slip value gives a constant delay over any number of words. Holding the level never adds further delay.
- R7: The slip value is sampled with each accepted word, so consecutive words may use different slips.
- R8: When `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold on the next clock, and `in_ready` is 0.
- R9: Only accepted words enter the carry history. Words offered while `in_ready` is 0 have no effect.
- R10: When the held word is taken and no new word is accepted in that cycle, `out_valid` is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slip_amt | input | SW | Level-held delay in bit times |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken this cycle |
| in_data | input | W | Input word, bit 0 serialized first |
| out_valid | output | 1 | Output word held |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | W | Re-aligned output word |

## Verification
The hardest case to reach is a change of the slip value while the output is stalled, with input words still being offered during the stall. If the design sampled the slip or updated its history at the wrong moment, the carried bits would come from the wrong word. The stimulus drives random stall patterns on both `in_valid` and `out_ready` and changes the slip on every cycle, including during stalls. A behavioural model that advances only on handshakes predicts every word. Separate phases hold slip at zero, at W-1 and at values beyond the clamp point, and check the first word after reset with a non-zero slip.

// File: rtl/tx_lane_slip_pkg.sv
package tx_lane_slip_pkg;
  // Effective slip: a raw control value limited to the largest legal delay.
  function automatic int limit_slip(input int raw, input int width);
    return (raw > width - 1) ? width - 1 : raw;
  endfunction
endpackage

// File: rtl/tx_slip_limit.sv
module tx_slip_limit #(
  parameter int W  = 32,
  parameter int SW = 6,
  localparam int EW = (W > 2) ? $clog2(W) : 1
) (
  input  logic [SW-1:0] slip_raw,
  output logic [EW-1:0] slip_eff
);
  import tx_lane_slip_pkg::*;
  always_comb slip_eff = EW'(limit_slip(int'(slip_raw), W));
endmodule

// File: rtl/tx_slip_funnel.sv
module tx_slip_funnel #(
  parameter int W = 32,
  localparam int EW = (W > 2) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  cur_word,
  input  logic [W-1:0]  prev_word,
  input  logic [EW-1:0] slip,
  output logic [W-1:0]  word_out
);
  logic [2*W-1:0] joined;
  assign joined = {cur_word, prev_word};
  // Output starts W-slip bits up the joined pair: the tail of the previous
  // word lands in the low (first serialized) positions.
  always_comb word_out = joined[W - int'(slip) +: W];
endmodule

// File: rtl/tx_slip_stage.sv
module tx_slip_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] shifted,
  input  logic         slip_zero,
  output logic [W-1:0] history,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      history   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= shifted;
      history   <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r10_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
  a_r2_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slip_zero) |=> (out_data == $past(in_data)));
  a_r7_take_fills: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  a_r9_history_only_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(history));
endmodule

// File: rtl/tx_lane_slip.sv
module tx_lane_slip #(
  parameter int W  = 32,
  parameter int SW = 6,
  localparam int EW = (W > 2) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] slip_amt,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data
);
  logic [EW-1:0] slip_eff;
  logic [W-1:0]  history;
  logic [W-1:0]  shifted;

  tx_slip_limit #(.W(W), .SW(SW)) u_limit (
    .slip_raw (slip_amt),
    .slip_eff (slip_eff)
  );

  tx_slip_funnel #(.W(W)) u_funnel (
    .cur_word  (in_data),
    .prev_word (history),
    .slip      (slip_eff),
    .word_out  (shifted)
  );

  tx_slip_stage #(.W(W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .shifted   (shifted),
    .slip_zero (slip_amt == '0),
    .history   (history),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: tb/tx_lane_slip_test.sv
`timescale 1ns/1ps
module tx_lane_slip_test;
  localparam int W  = 32;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] slip_amt = '0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          out_ready = 1'b0;
  logic          in_ready, out_valid;
  logic [W-1:0]  out_data;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // reference model state
  logic         m_valid = 1'b0;
  logic [W-1:0] m_data = '0;
  logic [W-1:0] m_hist = '0;

  tx_lane_slip #(.W(W), .SW(SW)) uut (.*);

  always #2 clk = ~clk;

  function automatic logic [W-1:0] ref_word(logic [W-1:0] cur, logic [W-1:0] prev, int raw);
    int s;
    logic [W-1:0] r;
    s = (raw >= W) ? W - 1 : raw;
    for (int j = 0; j < W; j++)
      r[j] = (j < s) ? prev[W - s + j] : cur[j - s];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 1'b0; m_hist = '0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_data = ref_word(in_data, m_hist, int'(slip_amt));
      m_hist = in_data;
      m_valid = 1'b1;
    end else if (out_ready) begin
      m_valid = 1'b0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic compare();
    checks++;
    if (out_valid !== m_valid || in_ready !== (!m_valid || out_ready)) begin
      fails++;
      $display("FAIL %s: valid/ready actual %b/%b expected %b/%b", tag,
               out_valid, in_ready, m_valid, !m_valid || out_ready);
    end
    if (m_valid) begin
      checks++;
      if (out_data !== m_data) begin
        fails++;
        $display("FAIL %s: data actual %h expected %h", tag, out_data, m_data);
      end
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] d, input int s, input logic r);
    @(negedge clk);
    compare();
    in_valid = v; in_data = d; slip_amt = SW'(s); out_ready = r;
  endtask

  task automatic stream(input int n, input int s, input logic rand_hs);
    for (int i = 0; i < n; i++)
      step(rand_hs ? 1'($urandom) : 1'b1, $urandom, s, rand_hs ? 1'($urandom) : 1'b1);
  endtask

  initial begin
    // R1: reset state, then first word after reset sees a cleared history
    tag = "R1";
    for (int i = 0; i < 4; i++) step(1'b1, '1, 5, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    compare();
    step(1'b1, 32'hFFFF_FFFF, 5, 1'b1);
    step(1'b0, '0, 5, 1'b1);
    // R2: pass-through
    tag = "R2"; stream(40, 0, 1'b0);
    // R3: assorted slips
    tag = "R3"; stream(30, 1, 1'b0); stream(30, 7, 1'b0); stream(30, 13, 1'b0);
    // R4: largest slip
    tag = "R4"; stream(30, W - 1, 1'b0);
    // R5: clamped control values
    tag = "R5"; stream(20, W, 1'b0); stream(20, 40, 1'b0); stream(20, 63, 1'b0);
    // R6: long constant run
    tag = "R6"; stream(300, 9, 1'b0);
    // R7: slip changes every word
    tag = "R7";
    for (int i = 0; i < 200; i++) step(1'b1, $urandom, int'($urandom % 64), 1'b1);
    // R8 / R9: random stalls with slip changing during stalls
    tag = "R8";
    for (int i = 0; i < 400; i++) step(1'($urandom), $urandom, int'($urandom % 64), 1'($urandom));
    tag = "R9"; stream(300, 17, 1'b1);
    // R10: drain with no new input
    tag = "R10";
    step(1'b1, $urandom, 3, 1'b0);
    step(1'b0, '0, 3, 1'b0);
    step(1'b0, '0, 3, 1'b1);
    step(1'b0, '0, 3, 1'b1);
    step(1'b0, '0, 3, 1'b1);
    summary();
  end
endmodule